// File: doc/BRIEF.md
# Voltage Identification Code Register with Sleep Override

This block holds the five-bit voltage identification code that programs a core regulator's target level and turns the code in use into a target in millivolts. The external code does not pass straight through. It is loaded only by a one-clock capture pulse, and that pulse comes from either edge of the synchronized mode-select level. When the system changes operating mode, the code present on the inputs at that moment becomes the new target. Between mode changes, activity on the code inputs is ignored.

A park request replaces the registered code with a fixed internal code, which is a parameter. When park is released, the registered code is used again and its value has not been disturbed. The block also raises two offset flags that tell the analog side which downward shift to apply: the battery shift or the nap (deep-sleep) shift. The nap shift takes priority over the battery shift. A park request removes both shifts. All three control inputs pass through a two-flop synchronizer before use.

Top module: `vid_target_ctrl`

## Requirements
- R1: For codes 0 to 15, target_mv equals 1750 minus 50 times the code (code 0 gives 1750, code 15 gives 1000).
- R2: For codes 16 to 31, target_mv equals 975 minus 25 times (code minus 16) (code 16 gives 975, code 31 gives 600).
- R3: A rising edge on mode_sel_n loads vid_in into the register, and the new code shows on code_used no later than four clocks after the edge.
- R4: A falling edge on mode_sel_n also loads vid_in, with the same latency.
- R5: A change on vid_in with no edge on mode_sel_n leaves code_used and target_mv unchanged.
- R6: After reset, the register holds code 31, so target_mv is 600 and both shift flags are 0.
- R7: While park is high, code_used equals the parameter PARK_CODE (default 19, 900 mV), and target_mv follows that code.
- R8: When park falls, code_used returns to the registered code.
- R9: shift_batt is 1 only when mode_sel_n is low, nap_n is high and park is low.
- R10: shift_deep is 1 when nap_n is low and park is low, whatever the level of mode_sel_n. The two shift flags are never both 1.
- R11: While park is high, both shift flags are 0.
- R12: A mode_sel_n pulse that starts and ends between two rising clock edges causes no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_in | input | 5 | External voltage identification code |
| mode_sel_n | input | 1 | Mode select. Low means battery mode, and either edge loads the code |
| nap_n | input | 1 | Low requests the nap (deep-sleep) shift |
| park | input | 1 | High substitutes the internal park code and removes both shifts |
| code_used | output | 5 | Code currently driving the target |
| target_mv | output | 11 | Target voltage in millivolts |
| shift_batt | output | 1 | Battery downward shift is active |
| shift_deep | output | 1 | Nap downward shift is active |

## Verification
A wrong value in the code register is visible on code_used and target_mv one clock after the bad load. Such a value stays visible until the next mode edge, so a sweep that loads all 32 codes with alternating edges finds a bad table entry or a missed edge within four clocks of that edge. A wrong synchronizer or edge flop shows up in one of three ways: a load that arrives late, a spurious load after a glitch, or a spurious load after a change on vid_in alone. Each of these is seen on code_used at the next sample. Errors in the shift priority appear on the two flags as soon as the synchronized controls settle, two clocks after an input change.

// File: rtl/vid_pkg.sv
package vid_pkg;

    localparam int CODE_W = 5;
    localparam int MV_W   = 11;
    localparam int CTRL_W = 3;

    typedef logic [CODE_W-1:0] vid_code_t;
    typedef logic [MV_W-1:0]   mv_t;

    // Control levels in their synchronized form.
    typedef struct packed {
        logic mode_n;
        logic nap_n;
        logic park;
    } ctrl_t;

    // Which downward shift applies.
    typedef struct packed {
        logic batt;
        logic deep;
    } shift_t;

    localparam int HI_BASE_MV = 1750;
    localparam int HI_STEP_MV = 50;
    localparam int LO_BASE_MV = 975;
    localparam int LO_STEP_MV = 25;

    function automatic mv_t code_to_mv(input vid_code_t c);
        int idx;
        int mv;
        idx = int'(c[CODE_W-2:0]);
        if (c[CODE_W-1] == 1'b0)
            mv = HI_BASE_MV - HI_STEP_MV * idx;
        else
            mv = LO_BASE_MV - LO_STEP_MV * idx;
        return mv_t'(mv);
    endfunction

endpackage

// File: rtl/vid_ctrl_sync.sv
module vid_ctrl_sync #(
    parameter int                        STAGES  = 2,
    parameter logic [vid_pkg::CTRL_W-1:0] RST_VAL = 3'b110
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [vid_pkg::CTRL_W-1:0] raw,
    output logic [vid_pkg::CTRL_W-1:0] synced
);
    localparam int W = vid_pkg::CTRL_W;

    logic [STAGES-1:0][W-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= RST_VAL;
                else if (s == 0)
                    chain[s] <= raw;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign synced = chain[STAGES-1];

endmodule

// File: rtl/vid_edge_strobe.sv
module vid_edge_strobe #(
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic strobe
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst)
            prev <= RST_LEVEL;
        else
            prev <= level;
    end

    assign strobe = level ^ prev;

    // R3 R4: every pulse reflects a level change seen on the previous clock
    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (prev != $past(prev)));                                   // R3
endmodule

// File: rtl/vid_code_store.sv
module vid_code_store #(
    parameter vid_pkg::vid_code_t RST_CODE  = 5'd31,
    parameter vid_pkg::vid_code_t PARK_CODE = 5'd19
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  vid_pkg::vid_code_t vid_in,
    input  logic               park,
    output vid_pkg::vid_code_t code_sel
);
    vid_pkg::vid_code_t held;

    always_ff @(posedge clk) begin
        if (rst)
            held <= RST_CODE;
        else if (load)
            held <= vid_in;
    end

    always_comb begin
        if (park)
            code_sel = PARK_CODE;
        else
            code_sel = held;
    end

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(held));                                           // R5
    AST_LOAD_TAKES_INPUT: assert property (@(posedge clk) disable iff (rst)
        load |=> (held == $past(vid_in)));                                  // R3
    AST_RESET_CODE: assert property (@(posedge clk)
        $past(rst) |-> (held == RST_CODE));                                 // R6
endmodule

// File: rtl/vid_shift_arb.sv
module vid_shift_arb (
    input  vid_pkg::ctrl_t  ctrl,
    output vid_pkg::shift_t shift
);
    always_comb begin
        shift = '0;
        if (!ctrl.park) begin
            if (!ctrl.nap_n)
                shift.deep = 1'b1;
            else if (!ctrl.mode_n)
                shift.batt = 1'b1;
        end
    end
endmodule

// File: rtl/vid_target_ctrl.sv
module vid_target_ctrl #(
    parameter int                 SYNC_STAGES = 2,
    parameter vid_pkg::vid_code_t PARK_CODE   = 5'd19,
    parameter vid_pkg::vid_code_t RST_CODE    = 5'd31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  vid_in,
    input  logic        mode_sel_n,
    input  logic        nap_n,
    input  logic        park,
    output logic [4:0]  code_used,
    output logic [10:0] target_mv,
    output logic        shift_batt,
    output logic        shift_deep
);
    import vid_pkg::*;

    ctrl_t     raw_ctrl;
    ctrl_t     sync_ctrl;
    logic      load;
    vid_code_t code_sel;
    shift_t    shift;

    assign raw_ctrl = '{mode_n: mode_sel_n, nap_n: nap_n, park: park};

    vid_ctrl_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_ctrl),
        .synced (sync_ctrl)
    );

    vid_edge_strobe #(
        .RST_LEVEL (1'b1)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .level  (sync_ctrl.mode_n),
        .strobe (load)
    );

    vid_code_store #(
        .RST_CODE  (RST_CODE),
        .PARK_CODE (PARK_CODE)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .vid_in   (vid_in),
        .park     (sync_ctrl.park),
        .code_sel (code_sel)
    );

    vid_shift_arb u_arb (
        .ctrl  (sync_ctrl),
        .shift (shift)
    );

    assign code_used  = code_sel;
    assign target_mv  = code_to_mv(code_sel);
    assign shift_batt = shift.batt;
    assign shift_deep = shift.deep;

    AST_SHIFT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(shift_batt && shift_deep));                                       // R10
    AST_PARK_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        sync_ctrl.park |-> (!shift_batt && !shift_deep));                   // R11
    AST_PARK_CODE: assert property (@(posedge clk) disable iff (rst)
        sync_ctrl.park |-> (code_used == PARK_CODE));                       // R7
    AST_TARGET_RANGE: assert property (@(posedge clk) disable iff (rst)
        (target_mv >= 11'd600) && (target_mv <= 11'd1750));                 // R1
endmodule

// File: tb/sim_vid_target_ctrl.sv
module sim_vid_target_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  vid_in;
    logic        mode_sel_n;
    logic        nap_n;
    logic        park;
    logic [4:0]  code_used;
    logic [10:0] target_mv;
    logic        shift_batt;
    logic        shift_deep;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    vid_target_ctrl u0 (
        .clk        (clk),
        .rst        (rst),
        .vid_in     (vid_in),
        .mode_sel_n (mode_sel_n),
        .nap_n      (nap_n),
        .park       (park),
        .code_used  (code_used),
        .target_mv  (target_mv),
        .shift_batt (shift_batt),
        .shift_deep (shift_deep)
    );

    function automatic int exp_mv(input int c);
        if (c < 16) return 1750 - 50 * c;
        return 1375 - 25 * c;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_shift(input string req, input int eb, input int ed);
        check(req, int'(shift_batt), eb);
        check(req, int'(shift_deep), ed);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=0", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int held;
        rst = 1'b1; vid_in = 5'd0; mode_sel_n = 1'b1; nap_n = 1'b1; park = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        settle();
        check("R6 code", int'(code_used), 31);
        check("R6 mv", int'(target_mv), 600);
        check_shift("R6 shift", 0, 0);

        // R1 R2 R3 R4: sweep all codes, alternating edge direction
        for (int c = 0; c < 32; c++) begin
            @(negedge clk);
            vid_in = 5'(c);
            mode_sel_n = ~mode_sel_n;
            settle();
            check((c % 2 == 0) ? "R4 falling edge load" : "R3 rising edge load",
                  int'(code_used), c);
            check((c < 16) ? "R1 mv" : "R2 mv", int'(target_mv), exp_mv(c));
            check("R9 batt follows mode", int'(shift_batt), mode_sel_n ? 0 : 1);
        end
        held = 31;

        // R5: vid change without an edge is ignored
        @(negedge clk);
        vid_in = 5'd4;
        settle();
        check("R5 code", int'(code_used), held);
        check("R5 mv", int'(target_mv), exp_mv(held));

        // R12: glitch between clock edges
        @(negedge clk);
        mode_sel_n = ~mode_sel_n;
        #1 mode_sel_n = ~mode_sel_n;
        settle();
        check("R12 glitch", int'(code_used), held);

        // load code 7 with mode high
        @(negedge clk);
        vid_in = 5'd7;
        mode_sel_n = ~mode_sel_n;
        settle();
        if (mode_sel_n == 1'b0) begin
            @(negedge clk);
            mode_sel_n = 1'b1;
            settle();
        end
        held = 7;
        check("R3 load 7", int'(code_used), 7);
        check_shift("R9 mode high no shift", 0, 0);

        // R9 / R10 priority
        @(negedge clk); mode_sel_n = 1'b0; settle();
        check_shift("R9 battery only", 1, 0);
        @(negedge clk); nap_n = 1'b0; settle();
        check_shift("R10 nap wins", 0, 1);
        @(negedge clk); mode_sel_n = 1'b1; settle();
        check_shift("R10 nap alone", 0, 1);

        // R7 R11: park
        @(negedge clk); park = 1'b1; mode_sel_n = 1'b0; settle();
        check("R7 park code", int'(code_used), 19);
        check("R7 park mv", int'(target_mv), 900);
        check_shift("R11 park clears", 0, 0);
        @(negedge clk); nap_n = 1'b1; settle();
        check_shift("R11 park clears batt", 0, 0);

        // R8: release park; edge during park loaded vid_in=7 again
        @(negedge clk); vid_in = 5'd20; park = 1'b0; settle();
        check("R8 release code", int'(code_used), held);
        check("R8 release mv", int'(target_mv), exp_mv(held));
        check_shift("R9 after park", 1, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule